// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between a 32-bit core and a byte-addressed, little-endian data memory. Each request carries an 8-bit opcode, a base address, a signed offset and, for stores, a source word. The unit adds the base and the offset to form the effective address. It decodes the access size and whether a load is signed, and it checks that the address is aligned to the access size. Accepted requests are registered onto the memory bus. Each one carries the full byte address, a write flag, per-byte write enables and, for stores, data that has been moved onto the correct byte lanes.

The memory answers a read one cycle after the request. The unit holds the lane, size and sign information for that read so that it can pick the addressed byte, half-word or word out of the returned word. It then widens that value to 32 bits, filling with zeros or with copies of the sign bit. A misaligned access raises a fault pulse and makes no memory request at all. An opcode that is not a load or store is ignored completely.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` read as a two's-complement value and sign-extended to the address width. It appears on `mem_addr` in the cycle after the request.
- R2: Only opcodes 0x03 through 0x0A are memory operations. Any other opcode leaves `mem_req`, `mem_be`, `misalign_fault` and `load_valid` low.
- R3: Opcode 0x03 loads a byte with zero fill and 0x04 loads a byte with sign fill. The byte is taken from bits [8*a+7:8*a] of the read word, where a = address[1:0].
- R4: Opcode 0x05 loads a half-word with zero fill and 0x06 loads a half-word with sign fill. The half-word is taken from bits [31:16] of the read word when address[1] is 1, and from bits [15:0] otherwise.
- R5: Opcode 0x07 returns the full read word unchanged.
- R6: Opcode 0x08 stores a byte. `mem_be` has only bit address[1:0] set, and `mem_wdata` carries the source's bits [7:0] copied into all four lanes.
- R7: Opcode 0x09 stores a half-word. `mem_be` is 4'b1100 when address[1] is 1 and 4'b0011 otherwise, and `mem_wdata` carries the source's bits [15:0] in both halves.
- R8: Opcode 0x0A stores a word, with `mem_be` = 4'b1111 and `mem_wdata` equal to the source.
- R9: An access is misaligned when it is a half-word access with address[0] = 1, or a word access with address[1:0] ≠ 0. A misaligned access raises `misalign_fault` for one cycle in the cycle after the request. That cycle has `mem_req` low and `mem_be` zero, and the access never produces `load_valid`.
- R10: `mem_we` is high with `mem_req` for stores and low for loads. `load_valid` is high exactly in the cycle after a load's `mem_req`, which is when `mem_rdata` is sampled, and `load_data` is zero whenever `load_valid` is low.
- R11: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 8 | Operation code |
| req_base | input | ADDR_W | Base address |
| req_offset | input | OFS_W | Signed offset |
| req_wsrc | input | 32 | Store source word |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high |
| mem_addr | output | ADDR_W | Effective byte address |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, valid the cycle after a read request |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |
| misalign_fault | output | 1 | Misaligned access pulse |

## Verification
The bench sweeps all sixteen low opcodes and two high ones over every byte lane, using both positive and negative offsets. Its reference memory is updated arithmetically. Lanes whose sign bits are set expose loads that fill with the wrong bit, or that take the wrong byte or half for address[1]. Odd and unaligned half-word and word addresses catch a design that lets a faulted store still write bytes, or that returns data for a faulted load. A negative offset catches an adder that does not sign-extend. Stores followed by loads of the same words catch wrong enable patterns.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
   localparam int DATA_W = 32;
   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = $clog2(LANES);

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef struct packed {
      logic      is_mem;
      logic      is_store;
      logic      is_signed;
      acc_size_e size;
   } acc_ctl_t;

   function automatic acc_ctl_t decode_op(input logic [7:0] op);
      acc_ctl_t c;
      c = '{is_mem: 1'b0, is_store: 1'b0, is_signed: 1'b0, size: SZ_BYTE};
      unique case (op)
         8'h03: c = '{1'b1, 1'b0, 1'b0, SZ_BYTE};
         8'h04: c = '{1'b1, 1'b0, 1'b1, SZ_BYTE};
         8'h05: c = '{1'b1, 1'b0, 1'b0, SZ_HALF};
         8'h06: c = '{1'b1, 1'b0, 1'b1, SZ_HALF};
         8'h07: c = '{1'b1, 1'b0, 1'b0, SZ_WORD};
         8'h08: c = '{1'b1, 1'b1, 1'b0, SZ_BYTE};
         8'h09: c = '{1'b1, 1'b1, 1'b0, SZ_HALF};
         8'h0A: c = '{1'b1, 1'b1, 1'b0, SZ_WORD};
         default: ;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/lsu_addr_check.sv
module lsu_addr_check
   import lsu_align_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W-1:0]  offset,
   input  acc_size_e         size,
   output logic [ADDR_W-1:0] addr,
   output logic              misaligned
);
   logic [ADDR_W-1:0] ofs_ext;

   // widen the offset, replicating its sign bit when narrower than the address
   generate
      if (OFS_W == ADDR_W) begin : g_ofs_full
         assign ofs_ext = offset;
      end else begin : g_ofs_sext
         assign ofs_ext = {{(ADDR_W-OFS_W){offset[OFS_W-1]}}, offset};
      end
   endgenerate

   assign addr = base + ofs_ext;

   always_comb begin
      unique case (size)
         SZ_HALF: misaligned = addr[0];
         SZ_WORD: misaligned = |addr[1:0];
         default: misaligned = 1'b0;
      endcase
   end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_align_pkg::*;
(
   input  acc_size_e          size,
   input  logic [LANE_W-1:0]  lane,
   input  logic [DATA_W-1:0]  src,
   output logic [DATA_W-1:0]  wdata,
   output logic [LANES-1:0]   be
);
   // each lane picks its byte and enable from the access size
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         localparam int HALF_IDX = i / 2;
         localparam int HB       = i % 2;
         always_comb begin
            unique case (size)
               SZ_BYTE: begin
                  wdata[8*i +: 8] = src[7:0];
                  be[i]           = (lane == LANE_W'(i));
               end
               SZ_HALF: begin
                  wdata[8*i +: 8] = src[8*HB +: 8];
                  be[i]           = (lane[1] == HALF_IDX[0]);
               end
               default: begin
                  wdata[8*i +: 8] = src[8*i +: 8];
                  be[i]           = 1'b1;
               end
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/lsu_load_lanes.sv
module lsu_load_lanes
   import lsu_align_pkg::*;
(
   input  acc_size_e          size,
   input  logic               sign_ext,
   input  logic [LANE_W-1:0]  lane,
   input  logic [DATA_W-1:0]  rdata,
   output logic [DATA_W-1:0]  data
);
   logic [7:0]  byte_v;
   logic [15:0] half_v;

   always_comb begin
      byte_v = rdata[{lane, 3'b000} +: 8];
      half_v = lane[1] ? rdata[31:16] : rdata[15:0];
      unique case (size)
         SZ_BYTE: data = {{(DATA_W-8){sign_ext & byte_v[7]}}, byte_v};
         SZ_HALF: data = {{(DATA_W-16){sign_ext & half_v[15]}}, half_v};
         default: data = rdata;
      endcase
   end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
   import lsu_align_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [7:0]        req_opcode,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [OFS_W-1:0]  req_offset,
   input  logic [31:0]       req_wsrc,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              load_valid,
   output logic [31:0]       load_data,
   output logic              misalign_fault
);
   generate
      if (OFS_W > ADDR_W) begin : g_bad_ofs
         $error("lsu_align_unit: OFS_W must not exceed ADDR_W");
      end
      if (ADDR_W < LANE_W + 1) begin : g_bad_addr
         $error("lsu_align_unit: ADDR_W too small for lane select");
      end
   endgenerate

   acc_ctl_t          ctl;
   logic [ADDR_W-1:0] eff_addr;
   logic              mis;
   logic [DATA_W-1:0] st_data;
   logic [LANES-1:0]  st_be;
   logic              go;

   assign ctl = decode_op(req_opcode);

   lsu_addr_check #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
      .base       (req_base),
      .offset     (req_offset),
      .size       (ctl.size),
      .addr       (eff_addr),
      .misaligned (mis)
   );

   lsu_store_lanes u_st (
      .size  (ctl.size),
      .lane  (eff_addr[LANE_W-1:0]),
      .src   (req_wsrc),
      .wdata (st_data),
      .be    (st_be)
   );

   assign go = req_valid & ctl.is_mem & ~mis;

   // stage 1: memory request; read side info held for the return cycle
   acc_size_e   s1_size, s2_size;
   logic        s1_signed, s2_signed;
   logic [LANE_W-1:0] s2_lane;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_req        <= 1'b0;
         mem_we         <= 1'b0;
         mem_addr       <= '0;
         mem_be         <= '0;
         mem_wdata      <= '0;
         misalign_fault <= 1'b0;
         s1_size        <= SZ_BYTE;
         s1_signed      <= 1'b0;
      end else begin
         mem_req        <= go;
         mem_we         <= go & ctl.is_store;
         mem_be         <= (go & ctl.is_store) ? st_be : '0;
         misalign_fault <= req_valid & ctl.is_mem & mis;
         if (go) begin
            mem_addr  <= eff_addr;
            s1_size   <= ctl.size;
            s1_signed <= ctl.is_signed;
            if (ctl.is_store) mem_wdata <= st_data;
         end
      end
   end

   // stage 2: memory returns data; steering info moves along with it
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_valid <= 1'b0;
         s2_size    <= SZ_BYTE;
         s2_signed  <= 1'b0;
         s2_lane    <= '0;
      end else begin
         load_valid <= mem_req & ~mem_we;
         s2_size    <= s1_size;
         s2_signed  <= s1_signed;
         s2_lane    <= mem_addr[LANE_W-1:0];
      end
   end

   logic [DATA_W-1:0] ld_ext;

   lsu_load_lanes u_ld (
      .size     (s2_size),
      .sign_ext (s2_signed),
      .lane     (s2_lane),
      .rdata    (mem_rdata),
      .data     (ld_ext)
   );

   assign load_data = load_valid ? ld_ext : '0;

   // ---------------- assertions ----------------
   assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_fault |-> (!mem_req && mem_be == 4'b0000));

   assert_fault_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_fault |=> !load_valid);

   assert_req_decoded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> $past(req_valid && req_opcode >= 8'h03 && req_opcode <= 8'h0A));

   assert_be_store_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_be != 4'b0000) |-> (mem_req && mem_we));

   assert_be_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                              4'b0011, 4'b1100, 4'b1111}));

   assert_load_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> load_valid);

   assert_idle_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !load_valid |-> (load_data == 32'h0));
endmodule

// File: tb/lsu_align_unit_tb.sv
module lsu_align_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_opcode = 8'h00;
   logic [31:0] req_base = '0;
   logic [15:0] req_offset = '0;
   logic [31:0] req_wsrc = '0;
   logic        mem_req, mem_we, load_valid, misalign_fault;
   logic [31:0] mem_addr, mem_wdata, load_data;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [31:0] mem_arr [16];
   logic [31:0] ref_arr [16];

   always #4 clk = ~clk;

   lsu_align_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
      .req_base(req_base), .req_offset(req_offset), .req_wsrc(req_wsrc),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .load_valid(load_valid),
      .load_data(load_data), .misalign_fault(misalign_fault)
   );

   // synchronous memory model, one-cycle read
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem_arr[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
         end else begin
            mem_rdata <= mem_arr[mem_addr[5:2]];
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic [7:0] op, input logic [31:0] base,
                        input logic [15:0] ofs, input logic [31:0] src);
      logic [31:0] ea, w, exp_ld, exp_wd;
      logic [3:0]  exp_be;
      logic [7:0]  bv;
      logic [15:0] hv;
      bit legal, st, sgn, mis;
      int sz;
      string tag;
      ea    = base + {{16{ofs[15]}}, ofs};
      legal = (op >= 8'h03 && op <= 8'h0A);
      st    = (op >= 8'h08 && op <= 8'h0A);
      sgn   = (op == 8'h04 || op == 8'h06);
      sz    = (op == 8'h03 || op == 8'h04 || op == 8'h08) ? 1 :
              (op == 8'h05 || op == 8'h06 || op == 8'h09) ? 2 : 4;
      mis   = legal && ((sz == 2 && ea[0]) || (sz == 4 && ea[1:0] != 2'b00));
      tag   = !legal ? "R2" : mis ? "R9" :
              (op == 8'h03 || op == 8'h04) ? "R3" :
              (op == 8'h05 || op == 8'h06) ? "R4" : (op == 8'h07) ? "R5" :
              (op == 8'h08) ? "R6" : (op == 8'h09) ? "R7" : "R8";
      exp_be = 4'b0000;
      exp_wd = 32'h0;
      if (st && !mis) begin
         if (sz == 1) begin exp_be = 4'b0001 << ea[1:0]; exp_wd = {4{src[7:0]}}; end
         else if (sz == 2) begin exp_be = ea[1] ? 4'b1100 : 4'b0011; exp_wd = {2{src[15:0]}}; end
         else begin exp_be = 4'b1111; exp_wd = src; end
      end
      @(negedge clk);
      req_valid = 1'b1; req_opcode = op; req_base = base; req_offset = ofs; req_wsrc = src;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " mem_req"}, {31'b0, mem_req}, {31'b0, legal && !mis});
      chk({"R9 fault ", tag}, {31'b0, misalign_fault}, {31'b0, mis});
      chk({tag, " mem_be"}, {28'b0, mem_be}, {28'b0, exp_be});
      if (legal && !mis) begin
         chk({"R1 addr ", tag}, mem_addr, ea);
         chk({"R10 we ", tag}, {31'b0, mem_we}, {31'b0, st});
         if (st) chk({tag, " wdata"}, mem_wdata, exp_wd);
      end
      @(negedge clk);
      chk({"R10 load_valid ", tag}, {31'b0, load_valid}, {31'b0, legal && !st && !mis});
      chk({"R10 fault width ", tag}, {31'b0, misalign_fault}, 32'h0);
      w  = ref_arr[ea[5:2]];
      bv = w[8*ea[1:0] +: 8];
      hv = ea[1] ? w[31:16] : w[15:0];
      exp_ld = (sz == 1) ? {{24{sgn & bv[7]}}, bv} :
               (sz == 2) ? {{16{sgn & hv[15]}}, hv} : w;
      if (legal && !st && !mis) chk({tag, " load_data"}, load_data, exp_ld);
      else chk({"R10 idle data ", tag}, load_data, 32'h0);
      if (st && !mis) begin
         for (int b = 0; b < 4; b++)
            if (exp_be[b]) ref_arr[ea[5:2]][8*b +: 8] = exp_wd[8*b +: 8];
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem_arr[i] = 32'h9A3C_71E5 + i * 32'h1357_9BDF;
         ref_arr[i] = mem_arr[i];
      end
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 mem_req", {31'b0, mem_req}, 32'h0);
      chk("R11 mem_we", {31'b0, mem_we}, 32'h0);
      chk("R11 mem_be", {28'b0, mem_be}, 32'h0);
      chk("R11 mem_addr", mem_addr, 32'h0);
      chk("R11 mem_wdata", mem_wdata, 32'h0);
      chk("R11 load", {31'b0, load_valid}, 32'h0);
      chk("R11 load_data", load_data, 32'h0);
      chk("R11 fault", {31'b0, misalign_fault}, 32'h0);
      rst_n = 1'b1;
      for (int k = 0; k < 18; k++) begin
         for (int a = 0; a < 16; a++) begin
            logic [7:0]  op;
            logic [31:0] tgt, base;
            logic [15:0] ofs;
            op  = (k < 16) ? 8'(k) : ((k == 16) ? 8'h83 : 8'hFF);
            tgt = ((a * 5) % 16) * 4 + (a % 4);
            if (a % 2 == 1) begin base = tgt + 32'd300; ofs = 16'hFED4; end
            else begin base = 32'h0001_0000 + tgt - 32'd16; ofs = 16'h0010; end
            do_op(op, base, ofs, 32'hC3A5_5A3C ^ (a * 32'h0111_0000) ^ 32'(k));
         end
      end
      // read back every word after the stores (R5, R8)
      for (int i = 0; i < 16; i++) do_op(8'h07, 32'(i * 4), 16'h0000, 32'h0);
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule